// File: doc/BRIEF.md
# Signed Multiply-by-Immediate Unit

This unit forms the signed product of an operand and an immediate for the three-operand integer multiply of a core that supports 16-bit and 32-bit operand sizes. The immediate comes in raw. A select input marks it either as a byte, which is sign-extended to the operand size, or as a value of the full operand width. The unit writes back only the low operand-width half of the double-width product. It also produces the overflow, carry, sign, zero and parity flags for that result.

One operation takes several steps. A `start` pulse while the unit is idle captures the inputs. The next cycle sign-extends them and launches the multiply. A parameter picks the multiplier: a shift-add engine that runs for one iteration per bit, or a single-cycle array product. Both give identical results. `busy` covers the whole operation. `done` pulses for one cycle when the result and flags become valid, and they then stay held until the next operation completes.

Top module: `imul_imm_unit`

## Requirements
- R1: When `imm_byte` is 1, only `imm_raw[7:0]` is used, taken as a signed byte and sign-extended to the operand width.
- R2: When `imm_byte` is 0, the immediate is `imm_raw[15:0]` in 16-bit mode (`wide`=0) or `imm_raw[31:0]` in 32-bit mode (`wide`=1), taken as signed. The operand is likewise `operand[15:0]` or `operand[31:0]`, taken as signed.
- R3: `result` is the low operand-width bits of the signed product. In 16-bit mode, `result[31:16]` is zero.
- R4: `flag_of` is 0 exactly when product bits 31..15 (16-bit mode) or 63..31 (32-bit mode) are all zeros or all ones. Otherwise it is 1.
- R5: `flag_cf` equals `flag_of` after every operation.
- R6: `flag_sf` is the top bit of the operand-width result. `flag_zf` is 1 exactly when that result is zero.
- R7: `flag_pf` is 1 when `result[7:0]` holds an even number of ones.
- R8: A `start` while idle raises `busy` in the next cycle. `done` is high for exactly one cycle per operation, and `busy` is low in that cycle.
- R9: A `start` while `busy` is high is ignored. The operation in flight completes with its original inputs.
- R10: Outputs stay unchanged between completions, whatever the inputs do.
- R11: The iterative and single-cycle multiplier variants produce identical results and flags.
- R12: After reset, `busy`, `done`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| operand | input | 32 | Register or memory operand |
| imm_raw | input | 32 | Raw immediate |
| imm_byte | input | 1 | 1: byte immediate, 0: full-width immediate |
| wide | input | 1 | 1: 32-bit operands, 0: 16-bit operands |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result and flags valid |
| result | output | 32 | Truncated product |
| flag_of | output | 1 | Product does not fit the operand width |
| flag_cf | output | 1 | Copy of the overflow flag |
| flag_sf | output | 1 | Sign of the result |
| flag_zf | output | 1 | Result is zero |
| flag_pf | output | 1 | Even parity of the low result byte |

## Verification
A corrupted capture register or a wrong multiplier accumulator shows up as a wrong `result` or `flag_of` at the very next `done` pulse. A stuck control state shows up instead as `busy` that never falls, or as a `done` that lasts more than one cycle. A wrong step counter in the iterative engine shows up as a product that has been shifted or only partly summed, so it differs from the single-cycle variant on the same inputs. Comparing the two variants side by side therefore catches that fault on the first operation whose multiplier has bits set near the top.

// File: rtl/imul_pkg.sv
package imul_pkg;

    localparam int IMUL_W  = 32;
    localparam int IMUL_HW = IMUL_W / 2;
    localparam int IMUL_PW = 2 * IMUL_W;
    localparam int IMUL_BW = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAP  = 2'd1,
        ST_MUL  = 2'd2
    } imul_state_e;

    typedef struct packed {
        logic of;
        logic cf;
        logic sf;
        logic zf;
        logic pf;
    } imul_flags_t;

    // Operand taken at the selected width and sign-extended to IMUL_W.
    function automatic logic [IMUL_W-1:0] sext_operand(
        input logic [IMUL_W-1:0] raw,
        input logic              is_wide
    );
        if (is_wide)
            return raw;
        return {{(IMUL_W-IMUL_HW){raw[IMUL_HW-1]}}, raw[IMUL_HW-1:0]};
    endfunction

    // Immediate: byte form or operand-width form, sign-extended to IMUL_W.
    function automatic logic [IMUL_W-1:0] sext_imm(
        input logic [IMUL_W-1:0] raw,
        input logic              is_byte,
        input logic              is_wide
    );
        if (is_byte)
            return {{(IMUL_W-IMUL_BW){raw[IMUL_BW-1]}}, raw[IMUL_BW-1:0]};
        return sext_operand(raw, is_wide);
    endfunction

    function automatic logic even_parity(input logic [IMUL_BW-1:0] v);
        return ~^v;
    endfunction

endpackage

// File: rtl/imul_ctrl.sv
module imul_ctrl
    import imul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IMUL_W-1:0] operand,
    input  logic [IMUL_W-1:0] imm_raw,
    input  logic              imm_byte,
    input  logic              wide,
    input  logic              mul_fin,
    output logic              mul_go,
    output logic [IMUL_W-1:0] a_ext,
    output logic [IMUL_W-1:0] b_ext,
    output logic              wide_q,
    output logic              busy,
    output logic              take_result
);

    imul_state_e       state;
    logic [IMUL_W-1:0] op_q;
    logic [IMUL_W-1:0] imm_q;
    logic              byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= '0;
            imm_q  <= '0;
            byte_q <= 1'b0;
            wide_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q   <= operand;
                        imm_q  <= imm_raw;
                        byte_q <= imm_byte;
                        wide_q <= wide;
                        state  <= ST_CAP;
                    end
                end
                ST_CAP: state <= ST_MUL;
                ST_MUL: begin
                    if (mul_fin)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        a_ext       = sext_operand(op_q, wide_q);
        b_ext       = sext_imm(imm_q, byte_q, wide_q);
        mul_go      = (state == ST_CAP);
        busy        = (state != ST_IDLE);
        take_result = (state == ST_MUL) && mul_fin;
    end

endmodule

// File: rtl/imul_mult.sv
module imul_mult #(
    parameter int W         = 32,
    parameter bit ITERATIVE = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod,
    output logic           fin
);

    localparam int PW = 2 * W;
    localparam int CW = $clog2(W) + 1;

    generate
        if (ITERATIVE) begin : g_shift_add
            logic [PW-1:0] acc;
            logic [PW-1:0] mcand;
            logic [W-1:0]  mplier;
            logic [W-1:0]  a_keep;
            logic [W-1:0]  b_keep;
            logic [CW-1:0] step;
            logic          run;
            logic [PW-1:0] acc_next;
            logic [PW-1:0] fix;

            always_comb begin
                acc_next = acc + (mplier[0] ? mcand : '0);
                // Unsigned product corrected to signed: subtract the
                // cross terms caused by negative operands.
                fix = (a_keep[W-1] ? {b_keep, {W{1'b0}}} : '0)
                    + (b_keep[W-1] ? {a_keep, {W{1'b0}}} : '0);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    acc    <= '0;
                    mcand  <= '0;
                    mplier <= '0;
                    a_keep <= '0;
                    b_keep <= '0;
                    step   <= '0;
                    run    <= 1'b0;
                    prod   <= '0;
                    fin    <= 1'b0;
                end else begin
                    fin <= 1'b0;
                    if (go) begin
                        acc    <= '0;
                        mcand  <= {{W{1'b0}}, a};
                        mplier <= b;
                        a_keep <= a;
                        b_keep <= b;
                        step   <= '0;
                        run    <= 1'b1;
                    end else if (run) begin
                        acc    <= acc_next;
                        mcand  <= mcand << 1;
                        mplier <= mplier >> 1;
                        step   <= step + 1'b1;
                        if (step == CW'(W - 1)) begin
                            run  <= 1'b0;
                            prod <= acc_next - fix;
                            fin  <= 1'b1;
                        end
                    end
                end
            end
        end else begin : g_array
            logic signed [PW-1:0] full;

            always_comb full = $signed(a) * $signed(b);

            always_ff @(posedge clk) begin
                if (rst) begin
                    prod <= '0;
                    fin  <= 1'b0;
                end else begin
                    fin <= go;
                    if (go)
                        prod <= full;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/imul_flags.sv
module imul_flags
    import imul_pkg::*;
(
    input  logic [IMUL_PW-1:0] prod,
    input  logic               wide,
    output logic [IMUL_W-1:0]  res,
    output imul_flags_t        flg
);

    logic [IMUL_W:0]  hi_wide;
    logic [IMUL_HW:0] hi_narrow;
    logic             fits;

    always_comb begin
        hi_wide   = prod[IMUL_PW-1:IMUL_W-1];
        hi_narrow = prod[IMUL_W-1:IMUL_HW-1];
        fits      = wide ? ((&hi_wide)   | ~(|hi_wide))
                         : ((&hi_narrow) | ~(|hi_narrow));
        res       = wide ? prod[IMUL_W-1:0]
                         : {{(IMUL_W-IMUL_HW){1'b0}}, prod[IMUL_HW-1:0]};
        flg.of    = ~fits;
        flg.cf    = ~fits;
        flg.sf    = wide ? prod[IMUL_W-1] : prod[IMUL_HW-1];
        flg.zf    = (res == '0);
        flg.pf    = even_parity(res[IMUL_BW-1:0]);
    end

endmodule

// File: rtl/imul_imm_unit.sv
module imul_imm_unit
    import imul_pkg::*;
#(
    parameter bit ITERATIVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IMUL_W-1:0] operand,
    input  logic [IMUL_W-1:0] imm_raw,
    input  logic              imm_byte,
    input  logic              wide,
    output logic              busy,
    output logic              done,
    output logic [IMUL_W-1:0] result,
    output logic              flag_of,
    output logic              flag_cf,
    output logic              flag_sf,
    output logic              flag_zf,
    output logic              flag_pf
);

    logic               mul_go;
    logic               mul_fin;
    logic               take_result;
    logic               wide_q;
    logic [IMUL_W-1:0]  a_ext;
    logic [IMUL_W-1:0]  b_ext;
    logic [IMUL_PW-1:0] prod;
    logic [IMUL_W-1:0]  res_c;
    imul_flags_t        flg_c;
    imul_flags_t        flg_q;
    logic [IMUL_W-1:0]  res_q;
    logic               done_q;

    imul_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .operand     (operand),
        .imm_raw     (imm_raw),
        .imm_byte    (imm_byte),
        .wide        (wide),
        .mul_fin     (mul_fin),
        .mul_go      (mul_go),
        .a_ext       (a_ext),
        .b_ext       (b_ext),
        .wide_q      (wide_q),
        .busy        (busy),
        .take_result (take_result)
    );

    imul_mult #(
        .W         (IMUL_W),
        .ITERATIVE (ITERATIVE)
    ) u_mult (
        .clk  (clk),
        .rst  (rst),
        .go   (mul_go),
        .a    (a_ext),
        .b    (b_ext),
        .prod (prod),
        .fin  (mul_fin)
    );

    imul_flags u_flags (
        .prod (prod),
        .wide (wide_q),
        .res  (res_c),
        .flg  (flg_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            flg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= take_result;
            if (take_result) begin
                res_q <= res_c;
                flg_q <= flg_c;
            end
        end
    end

    always_comb begin
        done    = done_q;
        result  = res_q;
        flag_of = flg_q.of;
        flag_cf = flg_q.cf;
        flag_sf = flg_q.sf;
        flag_zf = flg_q.zf;
        flag_pf = flg_q.pf;
    end

endmodule

// File: rtl/imul_imm_unit_chk.sv
module imul_imm_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        wide,
    input logic        busy,
    input logic        done,
    input logic [31:0] result,
    input logic        flag_of,
    input logic        flag_cf,
    input logic        flag_sf,
    input logic        flag_zf,
    input logic        flag_pf
);

    logic wide_seen;

    always_ff @(posedge clk) begin
        if (rst)
            wide_seen <= 1'b0;
        else if (start && !busy)
            wide_seen <= wide;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R5
    cf_of_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_cf == flag_of));

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(flag_of) && $stable(flag_sf)
                   && $stable(flag_zf) && $stable(flag_pf)));

    // R3
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !wide_seen) |-> (result[31:16] == 16'h0000));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_zf == (result == 32'h0)));

    // R7
    parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_pf == !$countones(result[7:0]) [0]));

endmodule

bind imul_imm_unit imul_imm_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .wide    (wide),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .flag_of (flag_of),
    .flag_cf (flag_cf),
    .flag_sf (flag_sf),
    .flag_zf (flag_zf),
    .flag_pf (flag_pf)
);

// File: tb/imul_imm_unit_test.sv
`timescale 1ns/1ps
module imul_imm_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [31:0] imm_raw = '0;
    logic        imm_byte = 1'b0;
    logic        wide = 1'b0;

    logic        busy_s, done_s, of_s, cf_s, sf_s, zf_s, pf_s;
    logic [31:0] res_s;
    logic        busy_f, done_f, of_f, cf_f, sf_f, zf_f, pf_f;
    logic [31:0] res_f;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    imul_imm_unit #(.ITERATIVE(1'b1)) uut (
        .clk(clk), .rst(rst), .start(start), .operand(operand),
        .imm_raw(imm_raw), .imm_byte(imm_byte), .wide(wide),
        .busy(busy_s), .done(done_s), .result(res_s),
        .flag_of(of_s), .flag_cf(cf_s), .flag_sf(sf_s),
        .flag_zf(zf_s), .flag_pf(pf_s)
    );

    imul_imm_unit #(.ITERATIVE(1'b0)) uut_fast (
        .clk(clk), .rst(rst), .start(start), .operand(operand),
        .imm_raw(imm_raw), .imm_byte(imm_byte), .wide(wide),
        .busy(busy_f), .done(done_f), .result(res_f),
        .flag_of(of_f), .flag_cf(cf_f), .flag_sf(sf_f),
        .flag_zf(zf_f), .flag_pf(pf_f)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Model: returns {of, sf, zf, pf, result}
    function automatic logic [35:0] model(input logic [31:0] op,
                                          input logic [31:0] imm,
                                          input logic is_byte,
                                          input logic is_wide);
        longint a;
        longint b;
        longint p;
        logic [63:0] pu;
        logic [31:0] r;
        logic of;
        logic [32:0] hw;
        logic [16:0] hn;
        a = is_wide ? longint'($signed(op)) : longint'($signed(op[15:0]));
        if (is_byte)
            b = longint'($signed(imm[7:0]));
        else
            b = is_wide ? longint'($signed(imm)) : longint'($signed(imm[15:0]));
        p  = a * b;
        pu = p;
        hw = pu[63:31];
        hn = pu[31:15];
        if (is_wide) begin
            r  = pu[31:0];
            of = !((hw == '0) || (hw == '1));
        end else begin
            r  = {16'h0, pu[15:0]};
            of = !((hn == '0) || (hn == '1));
        end
        return {of, (is_wide ? r[31] : r[15]), (r == 32'h0), ~^r[7:0], r};
    endfunction

    task automatic run_op(input logic [31:0] op, input logic [31:0] imm,
                          input logic is_byte, input logic is_wide,
                          input bit poke_busy, input string tag);
        logic [35:0] e;
        bit got_s;
        bit got_f;
        logic [31:0] hold_r;
        e = model(op, imm, is_byte, is_wide);
        @(negedge clk);
        operand = op; imm_raw = imm; imm_byte = is_byte; wide = is_wide;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8", "busy after start (iter)", {31'h0, busy_s}, 32'h1);
        check("R8", "busy after start (fast)", {31'h0, busy_f}, 32'h1);
        if (poke_busy) begin
            // R9: second start during busy with different inputs
            operand = ~op; imm_raw = ~imm; imm_byte = ~is_byte;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        got_s = 0; got_f = 0;
        for (int i = 0; i < 100 && !(got_s && got_f); i++) begin
            if (done_s && !got_s) begin
                got_s = 1;
                check("R8", "busy low at done", {31'h0, busy_s}, 32'h0);
            end
            if (done_f && !got_f) got_f = 1;
            if (!(got_s && got_f)) @(negedge clk);
        end
        if (!(got_s && got_f)) begin
            check("R8", "done never seen", {30'h0, got_s, got_f}, 32'h3);
            return;
        end
        @(negedge clk);
        check("R8", "done one cycle", {30'h0, done_s, done_f}, 32'h0);
        check(tag, "result", res_s, e[31:0]);
        check("R4", "flag_of", {31'h0, of_s}, {31'h0, e[35]});
        check("R5", "flag_cf", {31'h0, cf_s}, {31'h0, e[35]});
        check("R6", "sf,zf", {30'h0, sf_s, zf_s}, {30'h0, e[34], e[33]});
        check("R7", "flag_pf", {31'h0, pf_s}, {31'h0, e[32]});
        check("R11", "fast result", res_f, res_s);
        check("R11", "fast flags", {27'h0, of_f, cf_f, sf_f, zf_f, pf_f},
              {27'h0, of_s, cf_s, sf_s, zf_s, pf_s});
        // R10: change inputs without start, outputs must hold
        hold_r = res_s;
        operand = $urandom; imm_raw = $urandom; wide = ~wide;
        repeat (3) @(negedge clk);
        check("R10", "held result", res_s, hold_r);
        check("R10", "held flags", {30'h0, of_s, pf_s}, {30'h0, e[35], e[32]});
    endtask

    initial begin
        #(8 * 200000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12", "reset outputs",
              {res_s[30:0] | {31{busy_s | done_s}}, of_s | cf_s | sf_s | zf_s | pf_s},
              32'h0);
        check("R12", "reset result", res_s, 32'h0);

        // Directed corners
        run_op(32'h0000_8000, 32'h0000_FFFF, 1'b0, 1'b0, 0, "R2");   // 0x8000 * -1, 16-bit
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 0, "R2");   // 0x80000000 * -1
        run_op(32'h0000_0003, 32'h1234_5680, 1'b1, 1'b1, 0, "R1");   // imm8 0x80 = -128
        run_op(32'hABCD_0100, 32'h0000_0080, 1'b1, 1'b0, 0, "R1");   // imm8 -128, 16-bit
        run_op(32'h0000_C000, 32'h0000_0002, 1'b0, 1'b0, 0, "R3");   // -32768 fits
        run_op(32'h0000_4000, 32'h0000_0002, 1'b0, 1'b0, 0, "R3");   // 0x8000 overflows
        run_op(32'hC000_0000, 32'h0000_0002, 1'b0, 1'b1, 0, "R3");   // fits at 32-bit edge
        run_op(32'h4000_0000, 32'h0000_0002, 1'b0, 1'b1, 0, "R3");   // overflows
        run_op(32'h0000_7FFF, 32'h0000_0001, 1'b0, 1'b0, 0, "R3");
        run_op(32'h1234_0000, 32'h0000_0077, 1'b0, 1'b0, 0, "R6");   // zero result, 16-bit
        run_op(32'h0000_0011, 32'h0000_0000, 1'b0, 1'b1, 0, "R6");
        run_op(32'h0000_0005, 32'h0000_0007, 1'b1, 1'b1, 1, "R9");   // start while busy
        run_op(32'hFFFF_8001, 32'h0000_80FF, 1'b1, 1'b0, 1, "R9");

        // Constrained random
        for (int n = 0; n < 250; n++) begin
            logic [31:0] o;
            logic [31:0] m;
            int k;
            o = $urandom; m = $urandom; k = $urandom_range(0, 3);
            if (k == 0) o = {{17{o[31]}}, o[14:0]};
            if (k == 1) m = {{25{m[31]}}, m[6:0]};
            run_op(o, m, $urandom_range(0, 1), $urandom_range(0, 1),
                   ($urandom_range(0, 7) == 0), "R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule